// File: doc/BRIEF.md
# Hash Accelerator Interrupt and Status Aggregator

This block gathers the event pulses of a hashing accelerator and of its DMA channels into sticky status flags. It holds the per-source enables and the configuration bits, and it drives one interrupt line. Four engine events each set a flag in the low half of a combined 32-bit status word. These are context-input ready, partial-hash ready, input-buffer ready and result ready. Three DMA completion events set raw flags that appear in the upper half of the same word, at fixed scattered positions. Software reads the word either raw or filtered through the enables, over a small register bus that has a combinational read path.

A configuration register holds four fields: a global interrupt gate, a DMA request enable, a two-bit idle-mode field and a self-clearing soft-reset bit. A soft reset returns every register to its default. For a fixed number of cycles afterwards the block ignores events and writes, and a reset-done flag reports when the block is usable again.

Register word addresses are: 0 configuration, 1 system status, 2 raw status (write 1 clears engine flags), 3 masked status, 4 engine enable, 5 DMA mask, 6 DMA clear. Address 7 reads zero.

Top module: `hash_irq_agg`

## Requirements
- R1: After `rst_ni` is released, every register reads zero except system status bit 0 (reset done), which reads 1, and `irq_o`, `dma_en_o` and `idle_mode_o` are 0.
- R2: A high cycle on `eng_evt_i[i]` sets sticky engine flag i (bit 0 context ready, bit 1 partial hash ready, bit 2 input ready, bit 3 result ready) at the next edge. A write of 1 to bit i at address 2 clears it. If a set and a clear for the same flag fall in the same cycle, the set wins.
- R3: Address 4 holds the engine enable in bits [3:0]. The low half of the masked status (address 3) is the engine flags ANDed with this enable.
- R4: A high cycle on `dma_evt_i[j]` sets DMA raw flag j. In the raw and masked status words, DMA flag 0 appears at bit 19, flag 1 at bit 17 and flag 2 at bit 16. Bits 18 and 20 to 31 read 0.
- R5: Address 5 holds the DMA mask in bits [2:0]. The upper half of the masked status is the remapped DMA raw flags ANDed with this mask.
- R6: A write of 1 to bit j at address 6 clears DMA raw flag j unless an event for j arrives in the same cycle. Address 6 always reads 0.
- R7: `irq_o` is high exactly when configuration bit 1 (global interrupt enable) is set and at least one masked engine or masked DMA flag is set.
- R8: Configuration bit 2 is the DMA enable, driven on `dma_en_o`.
- R9: Writing 1 to configuration bit 0 clears every register at that edge. For the next 4 cycles configuration bit 0 reads 1, system status bit 0 reads 0, and all events and writes are ignored. After that, bit 0 clears itself and reset done reads 1.
- R10: Configuration bits [4:3] are the idle-mode field, driven on `idle_mode_o`. The field can be written once a soft reset has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| eng_evt_i | input | 4 | Engine event pulses (ctx, partial, input, result) |
| dma_evt_i | input | 3 | DMA completion pulses |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |
| dma_en_o | output | 1 | DMA requests allowed |
| idle_mode_o | output | 2 | Idle-mode field |

## Verification
Every flag, enable and configuration field is a register written at the clock edge that samples its event or write. The matching read value, `irq_o`, `dma_en_o` and `idle_mode_o` therefore change in the cycle just after that edge, with no further delay, because the read mux and the interrupt logic are combinational. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It compares all outputs 2 ns after every rising edge and also makes directed reads in the low clock phase. Soft-reset checks count exactly four busy cycles after the write edge before reset done is expected again.

// File: rtl/hia_pkg.sv
package hia_pkg;
  localparam int DW     = 32;
  localparam int AW     = 3;
  localparam int ENG_N  = 4;
  localparam int DMA_N  = 3;

  localparam logic [AW-1:0] A_CFG     = 3'd0;
  localparam logic [AW-1:0] A_STAT    = 3'd1;
  localparam logic [AW-1:0] A_RAW     = 3'd2;
  localparam logic [AW-1:0] A_MSK     = 3'd3;
  localparam logic [AW-1:0] A_ENG_EN  = 3'd4;
  localparam logic [AW-1:0] A_DMA_MSK = 3'd5;
  localparam logic [AW-1:0] A_DMA_CLR = 3'd6;

  localparam int CFG_SRST = 0;
  localparam int CFG_GIE  = 1;
  localparam int CFG_DMA  = 2;
  localparam int CFG_IDLE = 3;

  // DMA flag positions in the combined word; software decodes these
  function automatic logic [DW-1:0] dma_remap(logic [DMA_N-1:0] d);
    logic [DW-1:0] r;
    r     = '0;
    r[19] = d[0];
    r[17] = d[1];
    r[16] = d[2];
    return r;
  endfunction
endpackage

// File: rtl/hia_softrst.sv
module hia_softrst #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(CYC - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hia_flag_bank.sv
module hia_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      flag_o[g] <= 1'b0;
      else if (hold_i)                  flag_o[g] <= 1'b0;
      else if (evt_i[g])                flag_o[g] <= 1'b1;
      else if (clr_we_i && clr_i[g])    flag_o[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (hold_i)  en_o <= '0;
    else if (en_we_i) en_o <= en_i;
  end
endmodule

// File: rtl/hash_irq_agg.sv
module hash_irq_agg
  import hia_pkg::*;
#(
  parameter int SRST_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ENG_N-1:0] eng_evt_i,
  input  logic [DMA_N-1:0] dma_evt_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             irq_o,
  output logic             dma_en_o,
  output logic [1:0]       idle_mode_o
);
  logic             busy, start, hold, gie;
  logic [ENG_N-1:0] eng_sts, eng_en;
  logic [DMA_N-1:0] dma_raw, dma_msk;
  logic [DW-1:0]    raw_word, msk_word;

  assign start = bus_we_i && (bus_addr_i == A_CFG) && bus_wdata_i[CFG_SRST] && !busy;
  assign hold  = start || busy;

  hia_softrst #(.CYC(SRST_CYC)) u_srst (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy)
  );

  hia_flag_bank #(.N(ENG_N)) u_eng (
    .clk_i, .rst_ni, .hold_i(hold), .evt_i(eng_evt_i),
    .clr_we_i(bus_we_i && bus_addr_i == A_RAW), .clr_i(bus_wdata_i[ENG_N-1:0]),
    .en_we_i(bus_we_i && bus_addr_i == A_ENG_EN), .en_i(bus_wdata_i[ENG_N-1:0]),
    .flag_o(eng_sts), .en_o(eng_en)
  );

  hia_flag_bank #(.N(DMA_N)) u_dma (
    .clk_i, .rst_ni, .hold_i(hold), .evt_i(dma_evt_i),
    .clr_we_i(bus_we_i && bus_addr_i == A_DMA_CLR), .clr_i(bus_wdata_i[DMA_N-1:0]),
    .en_we_i(bus_we_i && bus_addr_i == A_DMA_MSK), .en_i(bus_wdata_i[DMA_N-1:0]),
    .flag_o(dma_raw), .en_o(dma_msk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie         <= 1'b0;
      dma_en_o    <= 1'b0;
      idle_mode_o <= 2'b00;
    end else if (hold) begin
      gie         <= 1'b0;
      dma_en_o    <= 1'b0;
      idle_mode_o <= 2'b00;
    end else if (bus_we_i && bus_addr_i == A_CFG) begin
      gie         <= bus_wdata_i[CFG_GIE];
      dma_en_o    <= bus_wdata_i[CFG_DMA];
      idle_mode_o <= bus_wdata_i[CFG_IDLE +: 2];
    end
  end

  assign raw_word = DW'(eng_sts) | dma_remap(dma_raw);
  assign msk_word = DW'(eng_sts & eng_en) | dma_remap(dma_raw & dma_msk);
  assign irq_o    = gie && (msk_word != '0);

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CFG: begin
        bus_rdata_o[CFG_SRST]      = busy;
        bus_rdata_o[CFG_GIE]       = gie;
        bus_rdata_o[CFG_DMA]       = dma_en_o;
        bus_rdata_o[CFG_IDLE +: 2] = idle_mode_o;
      end
      A_STAT:    bus_rdata_o[0] = !busy;
      A_RAW:     bus_rdata_o = raw_word;
      A_MSK:     bus_rdata_o = msk_word;
      A_ENG_EN:  bus_rdata_o[ENG_N-1:0] = eng_en;
      A_DMA_MSK: bus_rdata_o[DMA_N-1:0] = dma_msk;
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hia_checker.sv
module hia_checker
  import hia_pkg::*;
#(
  parameter int SRST_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ENG_N-1:0] eng_evt_i,
  input logic [DMA_N-1:0] dma_evt_i,
  input logic             bus_we_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [DW-1:0]    bus_wdata_i,
  input logic             irq_o,
  input logic             hold,
  input logic             busy,
  input logic             gie,
  input logic [ENG_N-1:0] eng_sts,
  input logic [ENG_N-1:0] eng_en,
  input logic [DMA_N-1:0] dma_raw
);
  logic [7:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_run <= '0;
    else if (!busy)       busy_run <= '0;
    else if (busy_run != 8'hff) busy_run <= busy_run + 1'b1;
  end

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((eng_evt_i != '0) && !hold) |=> ((eng_sts & $past(eng_evt_i)) == $past(eng_evt_i)));

  assert_dma_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_DMA_CLR && !hold)
      |=> ((dma_raw & $past(bus_wdata_i[DMA_N-1:0] & ~dma_evt_i)) == '0));

  assert_gate_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie |-> !irq_o);

  assert_eng_fires_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie && ((eng_sts & eng_en) != '0)) |-> irq_o);

  assert_busy_clean_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (eng_sts == '0 && dma_raw == '0 && !gie));

  assert_busy_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= 8'(SRST_CYC));
endmodule

bind hash_irq_agg hia_checker #(.SRST_CYC(SRST_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eng_evt_i(eng_evt_i), .dma_evt_i(dma_evt_i),
  .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .irq_o(irq_o), .hold(hold), .busy(busy), .gie(gie),
  .eng_sts(eng_sts), .eng_en(eng_en), .dma_raw(dma_raw)
);

// File: tb/test_hash_irq_agg.sv
`timescale 1ns/1ps
module test_hash_irq_agg;
  localparam int SRST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  eng_evt = '0;
  logic [2:0]  dma_evt = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, dma_en;
  logic [1:0]  idle;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hash_irq_agg #(.SRST_CYC(SRST)) i_hash_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .eng_evt_i(eng_evt), .dma_evt_i(dma_evt),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .dma_en_o(dma_en), .idle_mode_o(idle)
  );

  // reference model
  bit [3:0] m_eng, m_en;
  bit [2:0] m_dma, m_msk;
  bit       m_gie, m_dmaen;
  bit [1:0] m_idle;
  int       m_cnt;

  function automatic bit [31:0] place(bit [2:0] d);
    bit [31:0] v = 0;
    if (d[2]) v += 32'h0001_0000;
    if (d[1]) v += 32'h0002_0000;
    if (d[0]) v += 32'h0008_0000;
    return v;
  endfunction

  function automatic bit [31:0] model_read(bit [2:0] a);
    case (a)
      3'd0: return {27'd0, m_idle, m_dmaen, m_gie, bit'(m_cnt > 0)};
      3'd1: return {31'd0, bit'(m_cnt == 0)};
      3'd2: return {28'd0, m_eng} | place(m_dma);
      3'd3: return {28'd0, m_eng & m_en} | place(m_dma & m_msk);
      3'd4: return {28'd0, m_en};
      3'd5: return {29'd0, m_msk};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(bit [2:0] a);
    case (a)
      3'd0: return "R10";
      3'd1: return "R9";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R3";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic model_clear();
    m_eng = 0; m_en = 0; m_dma = 0; m_msk = 0;
    m_gie = 0; m_dmaen = 0; m_idle = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
      m_cnt = 0;
    end else if (m_cnt > 0) begin
      m_cnt--;
    end else if (we && addr == 3'd0 && wdata[0]) begin
      model_clear();
      m_cnt = SRST;
    end else begin
      if (we && addr == 3'd2) m_eng &= ~wdata[3:0];
      m_eng |= eng_evt;
      if (we && addr == 3'd6) m_dma &= ~wdata[2:0];
      m_dma |= dma_evt;
      if (we && addr == 3'd4) m_en = wdata[3:0];
      if (we && addr == 3'd5) m_msk = wdata[2:0];
      if (we && addr == 3'd0) begin
        m_gie = wdata[1]; m_dmaen = wdata[2]; m_idle = wdata[4:3];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(tag_of(addr), rdata, model_read(addr));
      chk("R7", {31'd0, irq}, {31'd0, m_gie && (model_read(3'd3) != 0)});
      chk("R8", {31'd0, dma_en}, {31'd0, m_dmaen});
      chk("R10", {30'd0, idle}, {30'd0, m_idle});
    end
  end

  task automatic wr(bit [2:0] a, bit [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic rd(bit [2:0] a, bit [31:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic eng_pulse(bit [3:0] v);
    @(negedge clk); eng_evt = v;
    @(negedge clk); eng_evt = 0;
  endtask

  task automatic dma_pulse(bit [2:0] v);
    @(negedge clk); dma_evt = v;
    @(negedge clk); dma_evt = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3'd1, 32'h1, "R1");
    rd(3'd0, 32'h0, "R1");
    rd(3'd2, 32'h0, "R1");
    chk("R1", {31'd0, irq}, 32'h0);
    // R2 sticky engine flags
    eng_pulse(4'b1001);
    repeat (2) @(negedge clk);
    rd(3'd2, 32'h9, "R2");
    rd(3'd3, 32'h0, "R3");
    // R3 enable
    wr(3'd4, 32'h8);
    rd(3'd3, 32'h8, "R3");
    chk("R7", {31'd0, irq}, 32'h0);
    wr(3'd0, 32'h2);
    chk("R7", {31'd0, irq}, 32'h1);
    wr(3'd2, 32'h8);
    rd(3'd2, 32'h1, "R2");
    chk("R7", {31'd0, irq}, 32'h0);
    // R4 DMA remap
    dma_pulse(3'b001);
    rd(3'd2, 32'h0008_0001, "R4");
    dma_pulse(3'b110);
    rd(3'd2, 32'h000B_0001, "R4");
    // R5 DMA mask
    wr(3'd5, 32'h2);
    rd(3'd3, 32'h0002_0000, "R5");
    chk("R7", {31'd0, irq}, 32'h1);
    // R6 DMA clear
    wr(3'd6, 32'h3);
    rd(3'd2, 32'h0001_0001, "R6");
    rd(3'd6, 32'h0, "R6");
    chk("R7", {31'd0, irq}, 32'h0);
    // R2 set beats clear in same cycle
    @(negedge clk); eng_evt = 4'b0100; we = 1; addr = 3'd2; wdata = 32'h4;
    @(negedge clk); eng_evt = 0; we = 0; wdata = 0;
    rd(3'd2, 32'h0001_0005, "R2");
    // R8, R10 configuration
    wr(3'd0, 32'h6);
    chk("R8", {31'd0, dma_en}, 32'h1);
    wr(3'd0, 32'h1E);
    chk("R10", {30'd0, idle}, 32'h3);
    // R9 soft reset
    @(negedge clk); we = 1; addr = 3'd0; wdata = 32'h1;
    @(negedge clk); we = 0; wdata = 0; addr = 3'd1; #1;
    chk("R9", rdata, 32'h0);
    addr = 3'd0; #1;
    chk("R9", rdata, 32'h1);
    eng_pulse(4'b1111);
    wr(3'd0, 32'h18);
    repeat (3) @(negedge clk);
    rd(3'd1, 32'h1, "R9");
    rd(3'd2, 32'h0, "R9");
    rd(3'd0, 32'h0, "R9");
    chk("R10", {30'd0, idle}, 32'h0);
    chk("R8", {31'd0, dma_en}, 32'h0);
    wr(3'd0, 32'h18);
    chk("R10", {30'd0, idle}, 32'h3);
    // R7 global gate off with enabled flags
    wr(3'd4, 32'hF);
    eng_pulse(4'b0010);
    chk("R7", {31'd0, irq}, 32'h0);
    wr(3'd0, 32'h2);
    chk("R7", {31'd0, irq}, 32'h1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule